// File: doc/BRIEF.md
# Packed AC-Link Frame Serializer

This block runs one full-duplex audio link of 256-bit frames. It works directly on the bit clock that the codec supplies. It drives the frame-sync line and shifts transmit data out on the serial output. In the same bits it captures the serial input. The frame is sixteen 16-bit slots, all of them enabled in both directions. The bits are treated as one packed stream: 20-bit sample fields cross slot edges and are never realigned.

Software exchanges data with the block in 64-bit words. Before each quarter of a frame it loads a transmit word. After each quarter it collects a receive word, which `buf_done` announces. One frame therefore takes four exchanges, and `seg_idx` reports which quarter the latest exchange covered. Missed reloads and missed reads are caught as sticky error flags.

Top module: `aclink_frame_engine`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `fsync`, `sdo`, `buf_done`, `seg_idx`, `tx_underflow` and `rx_overflow` are all 0.
- R2: The first rising edge with `en` high while idle starts a frame at bit 0. From that edge on, each frame lasts 256 edges. `fsync` is high during bits 0 to 15 and low during bits 16 to 255.
- R3: Transmit words go out MSB first. Each is updated on the rising edge, one word per 64-bit quarter, with no gap or realignment at 16-bit slot edges.
- R4: The block samples `sdi` on the falling edge, MSB first. On the rising edge that ends bit 63 of a quarter, `rx_data` takes the 64 bits just received, and `buf_done` pulses high for exactly one cycle.
- R5: `seg_idx` is updated with `buf_done` and gives the quarter just finished: 0, 1, 2 or 3. It returns to 0 with the first quarter of every frame.
- R6: Suppose no word has been loaded with `tx_load` since the last quarter began. At the next quarter boundary, that quarter sends all zeros and `tx_underflow` is set and held until reset.
- R7: Suppose `rx_read` has not been pulsed since the previous `buf_done`. At the next `buf_done`, `rx_data` is overwritten with the newer word and `rx_overflow` is set and held until reset.
- R8: A low `en` stops the link at the next rising edge: `fsync` and `sdo` go low. Raising `en` again restarts at bit 0 of a new frame with `fsync` high and the first quarter sending the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the codec; transmit on rise, receive on fall |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the link when high |
| tx_load | input | 1 | One-cycle strobe that writes `tx_data` into the transmit holding word |
| tx_data | input | 64 | Next 64-bit transmit word, MSB sent first |
| rx_read | input | 1 | One-cycle strobe acknowledging that `rx_data` was taken |
| sdi | input | 1 | Serial data from the codec |
| fsync | output | 1 | Frame sync, high for the first 16 bits of a frame |
| sdo | output | 1 | Serial data to the codec |
| rx_data | output | 64 | Last received 64-bit word |
| buf_done | output | 1 | One-cycle pulse at each 64-bit boundary |
| seg_idx | output | 2 | Frame quarter covered by the latest exchange |
| tx_underflow | output | 1 | Sticky: a quarter started with no loaded transmit word |
| rx_overflow | output | 1 | Sticky: a received word replaced one that had not been read |

## Verification
Suppose `en` is seen high on rising edge E while the link is idle. Then `fsync` and `sdo` for bit k are valid after edge E+k. `buf_done`, `rx_data` and `seg_idx` for a quarter appear after the edge that ends its bit 63. Both sticky flags change on that same boundary edge. A reference model in the bench advances once per rising edge, on the same input values the design sampled. It drives `sdi` 1 ns after the edge, so the value is stable at the falling edge. It compares every output 3 ns after the edge, after the registers have settled and before the next falling edge. Transmit words are loaded a few cycles after a boundary, never on one, so the hold register and the expected-word queue cannot disagree.

// File: rtl/acfe_pkg.sv
package acfe_pkg;
  localparam int unsigned FRAME_BITS_DEF = 256;
  localparam int unsigned SYNC_BITS_DEF  = 16;
  localparam int unsigned WORD_BITS_DEF  = 64;
endpackage

// File: rtl/acfe_timer.sv
// Bit position counter and frame-sync generator.
module acfe_timer #(
  parameter int unsigned FRAME_BITS = acfe_pkg::FRAME_BITS_DEF,
  parameter int unsigned SYNC_BITS  = acfe_pkg::SYNC_BITS_DEF,
  parameter int unsigned WORD_BITS  = acfe_pkg::WORD_BITS_DEF,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS),
  localparam int unsigned WBIT_W    = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic             running,
  output logic [CNT_W-1:0] pos,
  output logic             fsync,
  output logic             reload,
  output logic             word_end
);
  logic             start;
  logic [CNT_W-1:0] nxt;

  assign start    = en & ~running;
  assign word_end = running & en & (&pos[WBIT_W-1:0]);
  assign reload   = start | word_end;
  assign nxt      = (pos == CNT_W'(FRAME_BITS - 1)) ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running <= 1'b0;
      pos     <= '0;
      fsync   <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      pos     <= '0;
      fsync   <= 1'b1;
    end else begin
      pos     <= nxt;
      fsync   <= (nxt < CNT_W'(SYNC_BITS));
    end
  end
endmodule

// File: rtl/acfe_tx.sv
// Single-entry transmit hold word feeding an MSB-first shifter.
module acfe_tx #(
  parameter int unsigned WORD_BITS = acfe_pkg::WORD_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 halt,
  input  logic                 shift_en,
  input  logic                 reload,
  input  logic                 tx_load,
  input  logic [WORD_BITS-1:0] tx_data,
  output logic                 sdo,
  output logic                 underflow
);
  logic [WORD_BITS-1:0] hold_q;
  logic                 full_q;
  logic [WORD_BITS-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      full_q    <= 1'b0;
      sh_q      <= '0;
      underflow <= 1'b0;
    end else begin
      if (halt) begin
        sh_q <= '0;
      end else if (reload) begin
        if (full_q) begin
          sh_q <= hold_q;
        end else begin
          sh_q      <= '0;
          underflow <= 1'b1;
        end
      end else if (shift_en) begin
        sh_q <= {sh_q[WORD_BITS-2:0], 1'b0};
      end

      if (tx_load) begin
        hold_q <= tx_data;
        full_q <= 1'b1;
      end else if (reload && !halt) begin
        full_q <= 1'b0;
      end
    end
  end

  assign sdo = sh_q[WORD_BITS-1];
endmodule

// File: rtl/acfe_rx.sv
// Falling-edge receive shifter with word hand-off on the rising edge.
module acfe_rx #(
  parameter int unsigned WORD_BITS = acfe_pkg::WORD_BITS_DEF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_en,
  input  logic                 word_end,
  input  logic                 rd_ack,
  input  logic                 sdi,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 done,
  output logic                 overflow
);
  logic [WORD_BITS-1:0] sh_q;
  logic                 full_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (sample_en) begin
      sh_q <= {sh_q[WORD_BITS-2:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      done     <= 1'b0;
      full_q   <= 1'b0;
      overflow <= 1'b0;
    end else begin
      done <= word_end;
      if (word_end) begin
        rx_data <= sh_q;
        full_q  <= 1'b1;
        if (full_q && !rd_ack) overflow <= 1'b1;
      end else if (rd_ack) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aclink_frame_engine.sv
module aclink_frame_engine #(
  parameter int unsigned FRAME_BITS = acfe_pkg::FRAME_BITS_DEF,
  parameter int unsigned SYNC_BITS  = acfe_pkg::SYNC_BITS_DEF,
  parameter int unsigned WORD_BITS  = acfe_pkg::WORD_BITS_DEF,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS),
  localparam int unsigned SEG_W     = $clog2(FRAME_BITS / WORD_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 tx_load,
  input  logic [WORD_BITS-1:0] tx_data,
  input  logic                 rx_read,
  input  logic                 sdi,
  output logic                 fsync,
  output logic                 sdo,
  output logic [WORD_BITS-1:0] rx_data,
  output logic                 buf_done,
  output logic [SEG_W-1:0]     seg_idx,
  output logic                 tx_underflow,
  output logic                 rx_overflow
);
  logic             running;
  logic [CNT_W-1:0] pos;
  logic             reload;
  logic             word_end;

  acfe_timer #(.FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS), .WORD_BITS(WORD_BITS)) u_timer (
    .clk(clk), .rst(rst), .en(en), .running(running), .pos(pos),
    .fsync(fsync), .reload(reload), .word_end(word_end)
  );

  acfe_tx #(.WORD_BITS(WORD_BITS)) u_tx (
    .clk(clk), .rst(rst), .halt(~en), .shift_en(running & en), .reload(reload),
    .tx_load(tx_load), .tx_data(tx_data), .sdo(sdo), .underflow(tx_underflow)
  );

  acfe_rx #(.WORD_BITS(WORD_BITS)) u_rx (
    .clk(clk), .rst(rst), .sample_en(running), .word_end(word_end), .rd_ack(rx_read),
    .sdi(sdi), .rx_data(rx_data), .done(buf_done), .overflow(rx_overflow)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_idx <= '0;
    end else if (word_end) begin
      seg_idx <= pos[CNT_W-1 -: SEG_W];
    end
  end
endmodule

// File: rtl/acfe_chk.sv
module acfe_chk #(
  parameter int unsigned FRAME_BITS = acfe_pkg::FRAME_BITS_DEF,
  parameter int unsigned SYNC_BITS  = acfe_pkg::SYNC_BITS_DEF,
  parameter int unsigned WORD_BITS  = acfe_pkg::WORD_BITS_DEF,
  localparam int unsigned RUN_W     = $clog2(FRAME_BITS) + 1,
  localparam int unsigned SEG_W     = $clog2(FRAME_BITS / WORD_BITS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic                 tx_load,
  input logic [WORD_BITS-1:0] tx_data,
  input logic                 rx_read,
  input logic                 sdi,
  input logic                 fsync,
  input logic                 sdo,
  input logic [WORD_BITS-1:0] rx_data,
  input logic                 buf_done,
  input logic [SEG_W-1:0]     seg_idx,
  input logic                 tx_underflow,
  input logic                 rx_overflow
);
  logic [RUN_W-1:0] sync_run;

  always_ff @(posedge clk) begin
    if (rst || !fsync) sync_run <= '0;
    else               sync_run <= sync_run + 1'b1;
  end

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (rst) sync_run <= RUN_W'(SYNC_BITS));
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (rst) buf_done |=> !buf_done);
  // R4
  done_needs_en_chk: assert property (@(posedge clk) disable iff (rst) buf_done |-> $past(en));
  // R6
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst) tx_underflow |=> tx_underflow);
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst) rx_overflow |=> rx_overflow);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst) !$past(en) |-> (!fsync && !sdo));
endmodule

bind aclink_frame_engine acfe_chk #(
  .FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS), .WORD_BITS(WORD_BITS)
) u_chk (.*);

// File: tb/aclink_frame_engine_tb.sv
module aclink_frame_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        tx_load = 1'b0;
  logic [63:0] tx_data = '0;
  logic        rx_read = 1'b0;
  logic        sdi = 1'b0;
  logic        fsync, sdo, buf_done, tx_underflow, rx_overflow;
  logic [63:0] rx_data;
  logic [1:0]  seg_idx;

  aclink_frame_engine u_dut (
    .clk(clk), .rst(rst), .en(en), .tx_load(tx_load), .tx_data(tx_data),
    .rx_read(rx_read), .sdi(sdi), .fsync(fsync), .sdo(sdo), .rx_data(rx_data),
    .buf_done(buf_done), .seg_idx(seg_idx), .tx_underflow(tx_underflow),
    .rx_overflow(rx_overflow)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [63:0] txq[$];

  bit          mon_on = 1'b0;
  bit          m_act = 1'b0, m_uf = 1'b0, m_ov = 1'b0, m_full = 1'b0, m_done = 1'b0;
  int          m_pos = 0, m_frame = 0, m_seg = 0;
  logic [63:0] m_cur = '0, m_rxexp = '0;

  function automatic logic [63:0] rxw(int f, int s);
    logic [63:0] k;
    k = {32'(f), 32'(s)};
    return 64'h9E37_79B9_7F4A_7C15 ^ (k * 64'h0000_0001_0000_0F1B) ^ {k[31:0], k[63:32]};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reload_model();
    if (txq.size() > 0) m_cur = txq.pop_front();
    else begin m_cur = '0; m_uf = 1'b1; end
  endtask

  // Monitor: reference model stepped on each rising edge, compared 3 ns after it
  always @(posedge clk) begin
    if (mon_on) begin
      bit rd;
      logic [63:0] w;
      #1;
      rd = rx_read;
      m_done = 1'b0;
      if (!en) begin
        m_act = 1'b0; m_pos = 0;
      end else if (!m_act) begin
        m_act = 1'b1; m_pos = 0; m_frame++; reload_model();
      end else begin
        if (m_pos % 64 == 63) begin
          m_done = 1'b1; m_seg = m_pos / 64; m_rxexp = rxw(m_frame, m_pos / 64);
          reload_model();
        end
        if (m_pos == 255) begin m_pos = 0; m_frame++; end
        else m_pos++;
      end
      if (m_done) begin
        if (m_full && !rd) m_ov = 1'b1;
        m_full = 1'b1;
      end else if (rd) m_full = 1'b0;
      w = rxw(m_frame, m_pos / 64);
      sdi = m_act ? w[63 - (m_pos % 64)] : 1'b0;
      #2;
      chk(fsync == (m_act && m_pos < 16), "R2 fsync", 64'(fsync), 64'(m_act && m_pos < 16));
      chk(sdo == (m_act ? m_cur[63 - (m_pos % 64)] : 1'b0), "R3 sdo", 64'(sdo),
          64'(m_act ? m_cur[63 - (m_pos % 64)] : 1'b0));
      chk(buf_done == m_done, "R4 buf_done", 64'(buf_done), 64'(m_done));
      if (m_done) begin
        chk(rx_data == m_rxexp, "R4 rx_data", rx_data, m_rxexp);
        chk(seg_idx == 2'(m_seg), "R5 seg_idx", 64'(seg_idx), 64'(m_seg));
      end
      chk(tx_underflow == m_uf, "R6 tx_underflow", 64'(tx_underflow), 64'(m_uf));
      chk(rx_overflow == m_ov, "R7 rx_overflow", 64'(rx_overflow), 64'(m_ov));
    end
  end

  // Driver: inputs change 2 ns after a rising edge; expected words queued as loaded
  task automatic service(bit do_read, bit do_load, logic [63:0] word);
    @(posedge clk); #2;
    rx_read = do_read;
    if (do_load) begin tx_load = 1'b1; tx_data = word; txq.push_back(word); end
    @(posedge clk); #2;
    rx_read = 1'b0; tx_load = 1'b0;
  endtask

  task automatic wait_done();
    do @(posedge clk); while (!buf_done);
  endtask

  function automatic logic [63:0] txw(int i);
    return 64'hC3A5_5A3C_0FF0_1234 ^ (64'(i) * 64'h0123_4567_89AB_CDEF);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #3;
    // R1 reset state
    chk({fsync, sdo, buf_done, seg_idx, tx_underflow, rx_overflow} == '0, "R1 reset outputs",
        64'({fsync, sdo, buf_done, seg_idx, tx_underflow, rx_overflow}), 64'd0);
    #2;
    @(posedge clk); #2;
    rst = 1'b0; mon_on = 1'b1;
    @(posedge clk); #3;
    chk({fsync, sdo, buf_done, seg_idx, tx_underflow, rx_overflow} == '0, "R1 after reset",
        64'({fsync, sdo, buf_done, seg_idx, tx_underflow, rx_overflow}), 64'd0);
    service(1'b0, 1'b1, txw(0));
    @(posedge clk); #2; en = 1'b1;
    // R3 R4 R5: two full frames with every word serviced
    for (int i = 1; i <= 8; i++) begin
      wait_done();
      service(1'b1, 1'b1, txw(i));
    end
    // R6: one quarter left without a transmit word
    wait_done();
    service(1'b1, 1'b0, '0);
    wait_done();
    service(1'b1, 1'b1, txw(20));
    // R7: one received word never read
    wait_done();
    service(1'b0, 1'b1, txw(21));
    wait_done();
    service(1'b1, 1'b1, txw(22));
    // R8: stop mid-quarter, then restart at bit 0
    wait_done();
    service(1'b1, 1'b0, '0);
    repeat (10) @(posedge clk);
    #2; en = 1'b0;
    repeat (6) @(posedge clk);
    service(1'b0, 1'b1, txw(30));
    @(posedge clk); #2; en = 1'b1;
    for (int i = 31; i <= 34; i++) begin
      wait_done();
      service(1'b1, 1'b1, txw(i));
    end
    @(posedge clk); #2; en = 1'b0;
    repeat (4) @(posedge clk);
    mon_on = 1'b0;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule